// File: doc/BRIEF.md
# Memory Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics memory. It takes the device from power-on to a usable state. After reset it keeps clock enable and every byte mask high and sends only no-operation commands until a stable-clock wait has passed. The wait length comes from two parameters, the clock frequency in MHz and the wait time in microseconds. It then sends a fixed series of commands. The first is a precharge that closes both banks. After that come a set number of auto-refresh commands and a mode register load, in whichever order a parameter selects. A special mode register load, which turns load-color on or off, can follow as an option. Each command is followed by a configurable number of no-operation cycles.

The mode word, the refresh count, the gap lengths and the step order are all fixed when the block is elaborated. The controller only has to drive clock and reset and wait for `ready`. When `ready` rises, command ownership passes to the normal scheduler. A reset asserted at any point restarts the whole sequence.

Top module: `mem_init_seq`

## Requirements
- R1: `cke` and every bit of `dqm` are 1 during reset and in every cycle after it.
- R2: During reset and for the first CLK_MHZ*WAIT_US cycles after reset is released, the command is a no-operation. A no-operation is `cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, `special`=0, `addr`=0 and `bank`=0.
- R3: The first command that is not a no-operation is precharge-all. It appears in the cycle right after the wait and is encoded as `ras_n`=0, `cas_n`=1, `we_n`=0, `addr[8]`=1, with every other address bit and `bank` at 0.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued. REFRESH_COUNT must be at least 2. Each refresh is encoded as `ras_n`=0, `cas_n`=0, `we_n`=1, with `addr` and `bank` at 0.
- R5: The mode register load is encoded as `ras_n`=`cas_n`=`we_n`=0 and `special`=0. `addr[9:0]` equals MODE_WORD[9:0], while `addr[10]` and `bank` are both 0 whatever the value of MODE_WORD.
- R6: With MODE_FIRST=0, all refreshes come before the mode load. With MODE_FIRST=1, the mode load comes directly after the precharge gap and the refreshes follow it.
- R7: When SPECIAL_EN=1, the last command is a special mode load. It uses the same pins as the mode load but with `special`=1. `addr[6]` equals LOAD_COLOR and every other address bit and `bank` are 0. When SPECIAL_EN=0, no command with `special`=1 is ever sent.
- R8: Each command lasts one cycle and is followed by exactly the number of no-operation cycles set for its kind: GAP_PRE, GAP_REF, GAP_MRS or GAP_SMRS.
- R9: `ready` is 0 until the cycle after the last gap ends. From that cycle on it stays 1, and the command remains a no-operation until reset.
- R10: A reset asserted partway through the sequence returns the block to the wait phase, and the full sequence runs again from its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Byte masks, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| special | output | 1 | Selects the special mode register on a mode load |
| bank | output | 1 | Bank select |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions take for granted that reset is the only input that can change the sequence. The cycle counter they use therefore starts from the release of reset, and no command may appear before that counter reaches the wait length. The bench drives only reset and the clock. It releases reset on a falling edge, so the first sample after release always counts as cycle zero.

Two configurations run side by side, one with each step order and with the special load present in one and absent in the other. In every cycle the full pin vector of each is compared against a schedule that the bench computes from the parameters. One mode word sets bit 10 on purpose, to show that the mode load forces that bit to 0.

// File: rtl/mem_init_pkg.sv
package mem_init_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_PRE,
      CMD_REF,
      CMD_MRS,
      CMD_SMRS
   } init_cmd_e;

   typedef enum logic [1:0] {
      PH_WAIT,
      PH_ISSUE,
      PH_GAP,
      PH_READY
   } init_phase_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

endpackage

// File: rtl/mem_init_timer.sv
module mem_init_timer #(
   parameter int CNT_W     = 16,
   parameter int RESET_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RESET_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/mem_init_steps.sv
module mem_init_steps
   import mem_init_pkg::*;
#(
   parameter int STEP_W        = 4,
   parameter int REFRESH_COUNT = 2,
   parameter bit MODE_FIRST    = 1'b0,
   parameter bit SPECIAL_EN    = 1'b0
) (
   input  logic [STEP_W-1:0] step_idx,
   output init_cmd_e         step_kind
);

   localparam int REF_FIRST_IDX = MODE_FIRST ? 2 : 1;
   localparam int REF_LAST_IDX  = REF_FIRST_IDX + REFRESH_COUNT - 1;
   localparam int MRS_IDX       = MODE_FIRST ? 1 : REFRESH_COUNT + 1;
   localparam int SMRS_IDX      = REFRESH_COUNT + 2;

   localparam logic [STEP_W-1:0] REF_LO = STEP_W'(REF_FIRST_IDX);
   localparam logic [STEP_W-1:0] REF_HI = STEP_W'(REF_LAST_IDX);
   localparam logic [STEP_W-1:0] MRS_AT = STEP_W'(MRS_IDX);
   localparam logic [STEP_W-1:0] SM_AT  = STEP_W'(SMRS_IDX);

   logic      is_ref;
   logic      is_smrs;

   assign is_ref = (step_idx >= REF_LO) && (step_idx <= REF_HI);

   generate
      if (SPECIAL_EN) begin : g_special
         assign is_smrs = (step_idx == SM_AT);
      end else begin : g_plain
         assign is_smrs = 1'b0;
      end
   endgenerate

   always_comb begin
      if (step_idx == '0) begin
         step_kind = CMD_PRE;
      end else if (step_idx == MRS_AT) begin
         step_kind = CMD_MRS;
      end else if (is_ref) begin
         step_kind = CMD_REF;
      end else if (is_smrs) begin
         step_kind = CMD_SMRS;
      end else begin
         step_kind = CMD_NOP;
      end
   end

endmodule

// File: rtl/mem_init_pins.sv
module mem_init_pins
   import mem_init_pkg::*;
#(
   parameter int              ADDR_W      = 11,
   parameter int              PRE_ALL_BIT = 8,
   parameter int              COLOR_BIT   = 6,
   parameter logic [ADDR_W-1:0] MODE_WORD = '0,
   parameter bit              LOAD_COLOR  = 1'b0
) (
   input  init_cmd_e         kind,
   output cmd_pins_t         pins,
   output logic              special,
   output logic              bank,
   output logic [ADDR_W-1:0] addr
);

   localparam int RSV_BIT = ADDR_W - 1;

   always_comb begin
      pins    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      special = 1'b0;
      bank    = 1'b0;
      addr    = '0;
      unique case (kind)
         CMD_PRE: begin
            pins.ras_n        = 1'b0;
            pins.we_n         = 1'b0;
            addr[PRE_ALL_BIT] = 1'b1;
         end
         CMD_REF: begin
            pins.ras_n = 1'b0;
            pins.cas_n = 1'b0;
         end
         CMD_MRS: begin
            pins.ras_n    = 1'b0;
            pins.cas_n    = 1'b0;
            pins.we_n     = 1'b0;
            addr          = MODE_WORD;
            addr[RSV_BIT] = 1'b0;
         end
         CMD_SMRS: begin
            pins.ras_n      = 1'b0;
            pins.cas_n      = 1'b0;
            pins.we_n       = 1'b0;
            special         = 1'b1;
            addr[COLOR_BIT] = LOAD_COLOR;
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/mem_init_seq.sv
module mem_init_seq
   import mem_init_pkg::*;
#(
   parameter int                CLK_MHZ       = 100,
   parameter int                WAIT_US       = 200,
   parameter int                REFRESH_COUNT = 2,
   parameter int                GAP_PRE       = 2,
   parameter int                GAP_REF       = 7,
   parameter int                GAP_MRS       = 2,
   parameter int                GAP_SMRS      = 2,
   parameter bit                MODE_FIRST    = 1'b0,
   parameter bit                SPECIAL_EN    = 1'b0,
   parameter bit                LOAD_COLOR    = 1'b0,
   parameter int                ADDR_W        = 11,
   parameter int                DQM_W         = 4,
   parameter logic [ADDR_W-1:0] MODE_WORD     = 11'h032
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke,
   output logic [DQM_W-1:0]  dqm,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              special,
   output logic              bank,
   output logic [ADDR_W-1:0] addr,
   output logic              ready
);

   localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;
   localparam int NSTEPS      = 2 + REFRESH_COUNT + (SPECIAL_EN ? 1 : 0);
   localparam int STEP_W      = $clog2(NSTEPS + 1);
   localparam int CNT_W       = $clog2(WAIT_CYCLES + GAP_PRE + GAP_REF + GAP_MRS + GAP_SMRS + 1);
   localparam int PRE_ALL_BIT = 8;
   localparam int COLOR_BIT   = 6;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEPS - 1);

   generate
      if (REFRESH_COUNT < 2) begin : g_bad_ref
         $error("REFRESH_COUNT must be at least 2");
      end
      if (WAIT_CYCLES < 1) begin : g_bad_wait
         $error("wait length must be at least one cycle");
      end
      if (GAP_PRE < 1 || GAP_REF < 1 || GAP_MRS < 1 || GAP_SMRS < 1) begin : g_bad_gap
         $error("every gap must be at least one cycle");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must cover bits 10, 8 and 6");
      end
      if (DQM_W < 1) begin : g_bad_dqm
         $error("DQM_W must be positive");
      end
   endgenerate

   init_phase_e       phase_q;
   logic [STEP_W-1:0] step_q;
   init_cmd_e         step_kind;
   init_cmd_e         issue_kind;
   logic              timer_load;
   logic [CNT_W-1:0]  gap_len;
   logic              timer_done;
   cmd_pins_t         pins;

   mem_init_steps #(
      .STEP_W        (STEP_W),
      .REFRESH_COUNT (REFRESH_COUNT),
      .MODE_FIRST    (MODE_FIRST),
      .SPECIAL_EN    (SPECIAL_EN)
   ) u_steps (
      .step_idx  (step_q),
      .step_kind (step_kind)
   );

   always_comb begin
      unique case (step_kind)
         CMD_PRE:  gap_len = CNT_W'(GAP_PRE - 1);
         CMD_REF:  gap_len = CNT_W'(GAP_REF - 1);
         CMD_MRS:  gap_len = CNT_W'(GAP_MRS - 1);
         CMD_SMRS: gap_len = CNT_W'(GAP_SMRS - 1);
         default:  gap_len = '0;
      endcase
   end

   assign timer_load = (phase_q == PH_ISSUE);

   mem_init_timer #(
      .CNT_W     (CNT_W),
      .RESET_VAL (WAIT_CYCLES - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (gap_len),
      .expired  (timer_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WAIT;
         step_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_WAIT: begin
               if (timer_done) phase_q <= PH_ISSUE;
            end
            PH_ISSUE: begin
               phase_q <= PH_GAP;
            end
            PH_GAP: begin
               if (timer_done) begin
                  if (step_q == LAST_STEP) begin
                     phase_q <= PH_READY;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     phase_q <= PH_ISSUE;
                  end
               end
            end
            default: begin
               phase_q <= PH_READY;
            end
         endcase
      end
   end

   assign issue_kind = (phase_q == PH_ISSUE) ? step_kind : CMD_NOP;

   mem_init_pins #(
      .ADDR_W      (ADDR_W),
      .PRE_ALL_BIT (PRE_ALL_BIT),
      .COLOR_BIT   (COLOR_BIT),
      .MODE_WORD   (MODE_WORD),
      .LOAD_COLOR  (LOAD_COLOR)
   ) u_pins (
      .kind    (issue_kind),
      .pins    (pins),
      .special (special),
      .bank    (bank),
      .addr    (addr)
   );

   assign cs_n  = pins.cs_n;
   assign ras_n = pins.ras_n;
   assign cas_n = pins.cas_n;
   assign we_n  = pins.we_n;
   assign cke   = 1'b1;
   assign dqm   = '1;
   assign ready = (phase_q == PH_READY);

   // ---------------- assertions ----------------
   logic [CNT_W-1:0] chk_cyc_q;
   logic             chk_seen_q;
   logic             out_nop;
   logic             out_pre;

   assign out_nop = !cs_n && ras_n && cas_n && we_n && !special;
   assign out_pre = !cs_n && !ras_n && cas_n && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_cyc_q  <= '0;
         chk_seen_q <= 1'b0;
      end else begin
         if (chk_cyc_q != CNT_W'(WAIT_CYCLES)) chk_cyc_q <= chk_cyc_q + 1'b1;
         if (!out_nop) chk_seen_q <= 1'b1;
      end
   end

   p_strobes_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cke && (&dqm));

   p_wait_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_cyc_q < CNT_W'(WAIT_CYCLES)) |-> out_nop);

   p_first_is_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_seen_q && !out_nop) |-> (out_pre && addr[PRE_ALL_BIT]));

   p_mrs_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !ras_n && !cas_n && !we_n && !special) |-> (!addr[ADDR_W-1] && !bank));

   p_command_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_nop |=> out_nop);

   p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> out_nop);

   generate
      if (!SPECIAL_EN) begin : g_no_special_chk
         p_no_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !special);
      end
   endgenerate

endmodule

// File: tb/mem_init_seq_bench.sv
module mem_init_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int VW         = 23;

   typedef struct {
      int         wait_c;
      int         nref;
      int         gpre;
      int         gref;
      int         gmrs;
      int         gsm;
      bit         mode_first;
      bit         special_en;
      bit         load_color;
      logic [10:0] mode_word;
   } cfg_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   checks = 0;
   int   errors = 0;
   int   cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // configuration A: refreshes first, special load with load-color on
   logic        a_cke, a_cs, a_ras, a_cas, a_we, a_sp, a_bank, a_rdy;
   logic [3:0]  a_dqm;
   logic [10:0] a_addr;
   // configuration B: mode load first, no special load, bit 10 set in the word
   logic        b_cke, b_cs, b_ras, b_cas, b_we, b_sp, b_bank, b_rdy;
   logic [3:0]  b_dqm;
   logic [10:0] b_addr;

   mem_init_seq #(
      .CLK_MHZ(1), .WAIT_US(8), .REFRESH_COUNT(3),
      .GAP_PRE(2), .GAP_REF(3), .GAP_MRS(2), .GAP_SMRS(1),
      .MODE_FIRST(1'b0), .SPECIAL_EN(1'b1), .LOAD_COLOR(1'b1),
      .ADDR_W(11), .DQM_W(4), .MODE_WORD(11'h032)
   ) u_mem_init_seq (
      .clk(clk), .rst_n(rst_n), .cke(a_cke), .dqm(a_dqm), .cs_n(a_cs),
      .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we), .special(a_sp),
      .bank(a_bank), .addr(a_addr), .ready(a_rdy)
   );

   mem_init_seq #(
      .CLK_MHZ(1), .WAIT_US(5), .REFRESH_COUNT(2),
      .GAP_PRE(1), .GAP_REF(2), .GAP_MRS(3), .GAP_SMRS(1),
      .MODE_FIRST(1'b1), .SPECIAL_EN(1'b0), .LOAD_COLOR(1'b0),
      .ADDR_W(11), .DQM_W(4), .MODE_WORD(11'h427)
   ) u_mem_init_seq_b (
      .clk(clk), .rst_n(rst_n), .cke(b_cke), .dqm(b_dqm), .cs_n(b_cs),
      .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .special(b_sp),
      .bank(b_bank), .addr(b_addr), .ready(b_rdy)
   );

   cfg_t cfg_a = '{wait_c: 8, nref: 3, gpre: 2, gref: 3, gmrs: 2, gsm: 1,
                   mode_first: 1'b0, special_en: 1'b1, load_color: 1'b1,
                   mode_word: 11'h032};
   cfg_t cfg_b = '{wait_c: 5, nref: 2, gpre: 1, gref: 2, gmrs: 3, gsm: 1,
                   mode_first: 1'b1, special_en: 1'b0, load_color: 1'b0,
                   mode_word: 11'h427};

   // vector: {ready, cke, dqm[3:0], cs_n, ras_n, cas_n, we_n, special, bank, addr[10:0]}
   function automatic logic [VW-1:0] pack(logic rdy, logic [3:0] pins4, logic sp,
                                          logic [10:0] ad);
      return {rdy, 1'b1, 4'hF, pins4, sp, 1'b0, ad};
   endfunction

   function automatic logic [VW-1:0] expect_at(int t, cfg_t c, output string tag);
      int         at;
      int         nsteps;
      int         kind;
      int         gap;
      logic [10:0] ad;
      nsteps = 2 + c.nref + (c.special_en ? 1 : 0);
      if (t < c.wait_c) begin
         tag = "R1 R2 wait";
         return pack(1'b0, 4'b0111, 1'b0, 11'h000);
      end
      at = c.wait_c;
      for (int k = 0; k < nsteps; k++) begin
         // kind: 0 pre, 1 ref, 2 mrs, 3 special
         if (k == 0) kind = 0;
         else if (c.mode_first && k == 1) kind = 2;
         else if (!c.mode_first && k == c.nref + 1) kind = 2;
         else if (k == c.nref + 2) kind = 3;
         else kind = 1;
         gap = (kind == 0) ? c.gpre : (kind == 1) ? c.gref : (kind == 2) ? c.gmrs : c.gsm;
         if (t == at) begin
            case (kind)
               0: begin
                  tag = "R3 precharge-all";
                  return pack(1'b0, 4'b0010, 1'b0, 11'h100);
               end
               1: begin
                  tag = "R4 refresh";
                  return pack(1'b0, 4'b0001, 1'b0, 11'h000);
               end
               2: begin
                  tag = "R5 R6 mode load";
                  ad = {1'b0, c.mode_word[9:0]};
                  return pack(1'b0, 4'b0000, 1'b0, ad);
               end
               default: begin
                  tag = "R7 special load";
                  ad = 11'h000;
                  ad[6] = c.load_color;
                  return pack(1'b0, 4'b0000, 1'b1, ad);
               end
            endcase
         end
         at = at + 1;
         if (t < at + gap) begin
            tag = "R8 gap";
            return pack(1'b0, 4'b0111, 1'b0, 11'h000);
         end
         at = at + gap;
      end
      tag = "R9 ready";
      return pack(1'b1, 4'b0111, 1'b0, 11'h000);
   endfunction

   function automatic int seq_len(cfg_t c);
      int n;
      n = c.wait_c + (1 + c.gpre) + c.nref * (1 + c.gref) + (1 + c.gmrs);
      if (c.special_en) n = n + 1 + c.gsm;
      return n;
   endfunction

   task automatic check_vec(string who, string tag, logic [VW-1:0] act, logic [VW-1:0] exp,
                            int t);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, who, t, act, exp);
      end
   endtask

   task automatic sample(int t, string extra);
      string       tg;
      logic [VW-1:0] ex;
      ex = expect_at(t, cfg_a, tg);
      check_vec("cfgA", {extra, tg},
                {a_rdy, a_cke, a_dqm, a_cs, a_ras, a_cas, a_we, a_sp, a_bank, a_addr}, ex, t);
      ex = expect_at(t, cfg_b, tg);
      check_vec("cfgB", {extra, tg},
                {b_rdy, b_cke, b_dqm, b_cs, b_ras, b_cas, b_we, b_sp, b_bank, b_addr}, ex, t);
   endtask

   // run a sequence from reset release for n samples
   task automatic run_from_release(int n, string extra);
      @(negedge clk);
      rst_n = 1'b1;
      for (int t = 0; t < n; t++) begin
         #1;
         sample(t, extra);
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int total;
      total = seq_len(cfg_a);
      if (seq_len(cfg_b) > total) total = seq_len(cfg_b);
      total = total + 6;

      // reset state (R1, R2, R9): expected values equal the wait-phase vector
      repeat (3) @(negedge clk);
      #1;
      sample(0, "reset ");

      // full sequence in both configurations (R1 to R9)
      run_from_release(total, "");

      // R10: reset partway through, then the whole sequence again
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      sample(0, "R10 reset ");
      run_from_release(12, "R10 ");
      rst_n = 1'b0;
      @(negedge clk);
      #1;
      sample(0, "R10 midreset ");
      run_from_release(total, "R10 ");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule